// File: doc/BRIEF.md
# Modulator Clock Source Selector with Sync Output

This block decides which clock drives a switching modulator. It also produces a sync output so that several devices can be chained one after another. It runs in a fast system clock domain. The internal oscillator reaches it as a one-cycle `osc_tick` strobe. The sync input arrives as a level that has already been sampled into that domain. An internal clock level toggles on every oscillator tick, so one internal clock cycle spans two ticks.

When the active-low shutdown is released, the block waits one full internal clock cycle and then raises `ref_o`. A training window of `TRAIN_CYC` internal clock cycles follows. During that window the sync output carries the internal clock. At the end of the window `mod_o` rises. From then on, the modulator clock is one of two sources:
- the sync input, once it has shown a steady stream of edges;
- the internal clock, in every other case.

A static sync input silences the sync output. An input that starts toggling late first causes a few internal clock cycles to appear on the sync output before the block locks. When an external clock stops, the sync output freezes at once. After a timeout of `LOSS_TICKS` oscillator ticks without an edge, the modulator falls back to the internal clock. A change of source is taken only while the modulator clock is low.

Top module: `sync_clk_ctrl`

## Requirements
- R1: While `shdn_n` is low, `ref_o`, `mod_o`, `synco`, `ext_sel` and `mclk` are low from the first clock after it falls, and oscillator ticks and sync-input activity have no effect.
- R2: After shutdown release, `ref_o` rises in the clock after the second `osc_tick`, and not earlier.
- R3: `mod_o` rises in the clock after tick number 2 + 2*`TRAIN_CYC`, counted from release, and stays high with `ref_o` until shutdown.
- R4: The internal clock level equals the parity of ticks since release, starting at 0. While `ref_o` is high and `mod_o` is low, `synco` equals that level. `mclk` equals it whenever `ext_sel` is low.
- R5: After training, with a static sync input (held low or high), `synco` stays low, `ext_sel` stays low and `mclk` follows the internal clock.
- R6: While `ext_sel` is high, `synco` and `mclk` both equal the value of `synci` sampled one system clock earlier. `ext_sel` is high only while `mod_o` is high.
- R7: While fewer than `LOCK_EDGES` fresh edges have been seen, `ext_sel` stays low. While at least one fresh edge is present, `synco` carries the internal clock.
- R8: When an external clock stops, `synco` holds its level at once. `ext_sel` falls one clock after the `LOSS_TICKS`-th tick without an edge, provided `mclk` is low.
- R9: `ext_sel` changes only on a clock edge where `mclk` was low, except when shutdown clears it.
- R10: An edge is any change of `synci` between consecutive samples. An edge counts toward the lock only when fewer than `LOSS_TICKS` ticks have passed since the previous edge; otherwise the count restarts at one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_n | input | 1 | Active-low shutdown, synchronous |
| osc_tick | input | 1 | One-cycle strobe per internal oscillator half period |
| synci | input | 1 | Sampled sync input level |
| mclk | output | 1 | Selected modulator clock level |
| synco | output | 1 | Sync output level for the next device |
| ref_o | output | 1 | Reference phase reached after release |
| mod_o | output | 1 | Training window finished |
| ext_sel | output | 1 | Modulator runs from the sync input |

## Verification
The hardest conditions to reach are the gated switchovers. A lock completes while the internal clock is high. A clock stops while it is parked high. In both cases the source change must wait. The stimulus controls oscillator ticks one at a time, so the internal clock level is known exactly when the fourth edge lands or when the timeout expires. The lock window is swept over edge spacings from 1 to 10 ticks, across the loss threshold, with a fresh shutdown and training before each spacing.

// File: rtl/sync_clk_ctrl.sv
`timescale 1ns/1ps
module sync_clk_ctrl #(
  parameter int TRAIN_CYC  = 127,
  parameter int LOSS_TICKS = 8,
  parameter int LOCK_EDGES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shdn_n,
  input  logic osc_tick,
  input  logic synci,
  output logic mclk,
  output logic synco,
  output logic ref_o,
  output logic mod_o,
  output logic ext_sel
);
  localparam int PEND = 2 + 2 * TRAIN_CYC;
  localparam int PW   = $clog2(PEND + 1);
  localparam int LW   = $clog2(LOSS_TICKS + 1);
  localparam int EW   = $clog2(LOCK_EDGES + 1);
  localparam logic [PW-1:0] PEND_V = PW'(PEND);
  localparam logic [PW-1:0] REF_V  = PW'(2);
  localparam logic [LW-1:0] LOSS_V = LW'(LOSS_TICKS);
  localparam logic [EW-1:0] LOCK_V = EW'(LOCK_EDGES);

  logic          int_clk, synci_q;
  logic [PW-1:0] pcnt;
  logic [LW-1:0] gap;
  logic [EW-1:0] ecnt;

  wire edge_seen = synci ^ synci_q;
  wire lost      = (gap == LOSS_V);
  wire present   = (ecnt == LOCK_V) && !lost;
  wire fresh     = (ecnt != '0) && !lost;

  assign ref_o = (pcnt >= REF_V);
  assign mod_o = (pcnt == PEND_V);
  assign mclk  = ext_sel ? synci_q : int_clk;
  assign synco = mod_o ? (ext_sel ? synci_q : (fresh & int_clk))
                       : (ref_o & int_clk);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_clk <= 1'b0;
      synci_q <= 1'b0;
      pcnt    <= '0;
      gap     <= LOSS_V;
      ecnt    <= '0;
      ext_sel <= 1'b0;
    end else if (!shdn_n) begin
      int_clk <= 1'b0;
      synci_q <= 1'b0;
      pcnt    <= '0;
      gap     <= LOSS_V;
      ecnt    <= '0;
      ext_sel <= 1'b0;
    end else begin
      synci_q <= synci;
      if (osc_tick) int_clk <= ~int_clk;
      if (osc_tick && !mod_o) pcnt <= pcnt + PW'(1);
      if (edge_seen) begin
        gap <= '0;
        if (lost)                ecnt <= EW'(1);
        else if (ecnt != LOCK_V) ecnt <= ecnt + EW'(1);
      end else if (osc_tick && !lost) begin
        gap <= gap + LW'(1);
      end
      if (!mclk) ext_sel <= mod_o && present;
    end
  end

  assert_shdn_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |=> (!ref_o && !mod_o && !synco && !ext_sel && !mclk));

  assert_ref_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_o) |-> $past(osc_tick));

  assert_mod_needs_ref_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mod_o |-> ref_o);

  assert_ext_after_training_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_sel |-> mod_o);

  assert_switch_when_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(shdn_n) && (ext_sel != $past(ext_sel))) |-> !$past(mclk));
endmodule

// File: tb/sync_clk_ctrl_tb.sv
`timescale 1ns/1ps
module sync_clk_ctrl_tb;
  localparam int TRAIN = 5;
  localparam int LOSS  = 8;
  localparam int LOCK  = 4;
  localparam int MODK  = 2 + 2 * TRAIN;

  logic clk = 1'b0, rst_n = 1'b0, shdn_n = 1'b0, osc_tick = 1'b0, synci = 1'b0;
  logic mclk, synco, ref_o, mod_o, ext_sel;
  int checks = 0, fails = 0, k = 0;
  logic s = 1'b0;

  always #10 clk = ~clk;

  sync_clk_ctrl #(.TRAIN_CYC(TRAIN), .LOSS_TICKS(LOSS), .LOCK_EDGES(LOCK)) u_dut (
    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .osc_tick(osc_tick), .synci(synci),
    .mclk(mclk), .synco(synco), .ref_o(ref_o), .mod_o(mod_o), .ext_sel(ext_sel));

  task automatic chk(input string r, input logic a, input logic e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b k=%0d", r, a, e, k);
    end
  endtask

  task automatic cyc(input logic t, input logic v);
    osc_tick = t; synci = v;
    @(posedge clk); #2;
    osc_tick = 1'b0;
  endtask

  task automatic tick(input logic v);
    cyc(1'b1, v); k++;
  endtask

  task automatic restart();
    shdn_n = 1'b0; s = 1'b0; cyc(1'b0, 1'b0);
    shdn_n = 1'b1; k = 0;
  endtask

  task automatic lock_on();
    for (int i = 0; i < 6; i++) begin s = ~s; cyc(1'b0, s); end
    if (k % 2 == 1) tick(s);
    cyc(1'b0, s); cyc(1'b0, s);
    chk("R6 lock reached", ext_sel, 1'b1);
  endtask

  task automatic done();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #4000000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    done();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    cyc(1'b0, 1'b0);
    chk("R1 reset ref", ref_o, 1'b0);
    chk("R1 reset mod", mod_o, 1'b0);
    chk("R1 reset synco", synco, 1'b0);
    chk("R1 reset ext", ext_sel, 1'b0);
    cyc(1'b1, 1'b1); cyc(1'b1, 1'b0); cyc(1'b1, 1'b1);
    chk("R1 ticks ignored mclk", mclk, 1'b0);
    chk("R1 ticks ignored ref", ref_o, 1'b0);
    chk("R1 ticks ignored synco", synco, 1'b0);

    // training sequence, static low input
    restart();
    for (int i = 0; i < MODK; i++) begin
      tick(1'b0);
      chk("R2 ref timing", ref_o, k >= 2);
      chk("R3 mod timing", mod_o, k >= MODK);
      chk("R4 synco internal", synco, (k >= 2 && k < MODK) ? logic'(k % 2) : 1'b0);
      chk("R4 mclk internal", mclk, logic'(k % 2));
    end
    for (int i = 0; i < 6; i++) begin
      tick(1'b0);
      chk("R5 static low synco", synco, 1'b0);
      chk("R5 static low ext", ext_sel, 1'b0);
      chk("R5 static low mclk", mclk, logic'(k % 2));
      chk("R3 mod held", mod_o, 1'b1);
    end

    // static high input
    restart(); s = 1'b1;
    for (int i = 0; i < MODK + 4; i++) tick(1'b1);
    chk("R5 static high synco", synco, 1'b0);
    chk("R5 static high ext", ext_sel, 1'b0);
    chk("R5 static high mclk", mclk, logic'(k % 2));

    // late-starting clock: fewer than LOCK edges
    for (int e = 0; e < LOCK - 1; e++) begin
      s = ~s; cyc(1'b0, s);
      chk("R7 synco internal after edge", synco, logic'(k % 2));
      tick(s);
      chk("R7 synco internal after tick", synco, logic'(k % 2));
      chk("R7 no early switch", ext_sel, 1'b0);
    end
    // k is odd here: internal clock high blocks the switch
    s = ~s; cyc(1'b0, s);
    for (int i = 0; i < 3; i++) begin
      cyc(1'b0, s);
      chk("R9 switch waits mclk low", ext_sel, 1'b0);
    end
    tick(s);
    chk("R9 still internal at falling tick", ext_sel, 1'b0);
    cyc(1'b0, s);
    chk("R9 switch after mclk low", ext_sel, 1'b1);

    // running from the external clock
    for (int i = 0; i < 20; i++) begin
      if (i % 3 != 1) s = ~s;
      cyc(logic'(i % 4 == 0), s);
      if (i % 4 == 0) k++;
      chk("R6 synco follows synci", synco, s);
      chk("R6 mclk follows synci", mclk, s);
      chk("R6 ext held", ext_sel, 1'b1);
    end

    // loss while parked low
    if (s) begin s = 1'b0; cyc(1'b0, 1'b0); end
    for (int j = 1; j <= LOSS; j++) begin
      tick(1'b0);
      chk("R8 synco frozen", synco, 1'b0);
      chk("R8 ext held before timeout", ext_sel, 1'b1);
    end
    cyc(1'b0, 1'b0);
    chk("R8 fallback after timeout", ext_sel, 1'b0);
    chk("R8 mclk internal after fallback", mclk, logic'(k % 2));
    chk("R8 synco quiet after fallback", synco, 1'b0);

    // loss while parked high
    lock_on();
    if (!s) begin s = 1'b1; cyc(1'b0, 1'b1); end
    for (int j = 0; j <= LOSS; j++) tick(1'b1);
    chk("R9 held while mclk high", ext_sel, 1'b1);
    chk("R8 synco frozen high", synco, 1'b1);
    s = 1'b0; cyc(1'b0, 1'b0); cyc(1'b0, 1'b0);
    chk("R9 release once mclk low", ext_sel, 1'b0);

    // shutdown from external mode
    lock_on();
    shdn_n = 1'b0; cyc(1'b0, s);
    chk("R1 shutdown ext", ext_sel, 1'b0);
    chk("R1 shutdown mod", mod_o, 1'b0);
    chk("R1 shutdown ref", ref_o, 1'b0);
    chk("R1 shutdown mclk", mclk, 1'b0);
    for (int i = 0; i < 4; i++) begin
      s = ~s; cyc(1'b1, s);
      chk("R1 synco held low", synco, 1'b0);
    end

    // sweep edge spacing across the loss window
    for (int g = 1; g <= 10; g++) begin
      restart();
      for (int i = 0; i < MODK; i++) tick(1'b0);
      for (int e = 1; e <= LOCK; e++) begin
        s = ~s; cyc(1'b0, s);
        if (e < LOCK) repeat (g) tick(s);
      end
      if (k % 2 == 1) tick(s);
      cyc(1'b0, s);
      chk($sformatf("R10 lock with gap %0d", g), ext_sel, g < LOSS);
    end

    done();
  end
endmodule